// File: doc/BRIEF.md
# Smart card channel fault supervisor

This block watches two smart card channels (called A and B) for electrical faults. It raises a sticky fault flag and a deactivation request for a channel once a fault is confirmed. Its inputs are comparator flags for supply undervoltage and overcurrent, and compare flags that show whether the card clock and card reset pins disagree with their intended values. It also takes one shared over-temperature flag, a card-presence pin per channel with a selectable polarity, and the command word that carries each channel's supply-voltage select. The comparators, the regulators and the power-down sequencer sit outside the block.

Most conditions have to hold without a break for a whole timeout window before they count as a fault. The clock-pin mismatch works differently. It adds up mismatching cycles over a longer window and does not forget them when the clock matches again, so a clock that runs freely but wrongly is still caught. A missing card is a fault at once if the channel is powered, or if a command tries to power it. Writing a zero voltage select to a channel clears that channel's fault.

Top module: `card_fault_supervisor`

## Requirements
- R1: An undervoltage flag on a powered channel sets that channel's fault after it has been high for TIMEOUT_CYCLES consecutive clock cycles. A drop before then restarts the count, and TIMEOUT_CYCLES-1 cycles are not enough.
- R2: An overcurrent flag on a powered channel sets the fault after TIMEOUT_CYCLES consecutive high cycles, and not after TIMEOUT_CYCLES-1.
- R3: A reset-pin mismatch flag on a powered channel sets the fault after TIMEOUT_CYCLES consecutive high cycles, and not after TIMEOUT_CYCLES-1.
- R4: A clock-pin mismatch sets the fault once CLK_WINDOW_CYCLES mismatching cycles have been seen in total since the channel was powered. Cycles where the clock matches in between do not reset that total.
- R5: An over-temperature flag held for TIMEOUT_CYCLES consecutive cycles sets the faults of both channels in the same cycle, whether or not they are powered.
- R6: Card absence is decoded as presence pin XOR polarity select, so with polarity 0 a high pin means absent and with polarity 1 a low pin means absent. An absent card on a powered channel sets its fault one clock edge later, with no timeout.
- R7: A command that writes a non-zero voltage select to a channel whose card is absent sets that channel's fault at the same clock edge that loads the command.
- R8: Channel B's voltage select is command bits [1:0] and channel A's is bits [9:8]. Writing 00 to a channel's field clears its fault and its counters. A write of a non-zero field to the other channel leaves that channel's fault unchanged.
- R9: Each deactivation request bit (bit 0 = B, bit 1 = A) is high for exactly the one cycle in which that channel's fault flag first reads 1. The fault flag stays set afterwards.
- R10: The status word shows channel B's fault on bit 4 and channel A's fault on bit 12, and every other bit reads 0.
- R11: After reset the status word and both deactivation requests are 0.
- R12: While a channel's voltage select is 00, its undervoltage, overcurrent, reset-mismatch, clock-mismatch and absence inputs cannot set its fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | One-cycle strobe that loads cmdWord |
| cmdWord | input | 16 | Command word; [1:0] = voltage select B, [9:8] = voltage select A |
| uvFlag | input | 2 | Undervoltage comparator flags (bit 0 = B, bit 1 = A) |
| ocFlag | input | 2 | Overcurrent comparator flags |
| clkMismatch | input | 2 | Clock pin differs from its intended level |
| rstMismatch | input | 2 | Reset pin differs from its intended level |
| otFlag | input | 1 | Junction over-temperature flag |
| presPin | input | 2 | Card presence pins |
| presPolarity | input | 1 | Presence polarity select |
| statusWord | output | 16 | Bit 4 = fault B, bit 12 = fault A |
| deactReq | output | 2 | One-cycle deactivation requests (bit 0 = B, bit 1 = A) |

## Verification
Each timed condition is held for exactly the timeout and for one cycle less. This separates the cycle that confirms a fault from the one before it, on each channel. A clock mismatch that alternates with matching cycles must fault after the right total. An undervoltage that toggles the same way must never fault, which shows the difference between accumulating and restarting. Absence under both polarities, a power-up request with no card, a clear of only one channel and stimulus on an unpowered channel each test one gating or priority rule.

// File: rtl/fault_sup_pkg.sv
`timescale 1ns/1ps
package fault_sup_pkg;
  localparam int NUM_CH  = 2;
  localparam int CMD_W   = 16;
  localparam int VSEL_W  = 2;
  localparam int CH_STRIDE = 8;
  localparam int STAT_FAULT_BIT = 4;

  typedef struct packed {
    logic [NUM_CH-1:0] clearCh;
    logic [NUM_CH-1:0] powered;
    logic [NUM_CH-1:0] absentFault;
  } ctrlStrobes_t;
endpackage

// File: rtl/fault_persist_timer.sv
`timescale 1ns/1ps
module fault_persist_timer #(
  parameter int LIMIT = 16,
  parameter bit ACCUM = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cond,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (cond) begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
    end else if (!ACCUM) cnt <= '0;
  end

  assign hit = enable && cond && (cnt == LAST);

  generate
    if (!ACCUM && LIMIT > 1) begin : gRestart
      // R1 R2 R3: a single low cycle forbids a hit on the next cycle
      a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> !hit);
    end
    if (ACCUM) begin : gKeep
      a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cond) |=> (cnt == $past(cnt)));
    end
  endgenerate
endmodule

// File: rtl/fault_sup_ctrl.sv
`timescale 1ns/1ps
module fault_sup_ctrl
  import fault_sup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [NUM_CH-1:0] presPin,
  input  logic              presPolarity,
  output ctrlStrobes_t      strobes
);
  logic [NUM_CH-1:0][VSEL_W-1:0] vselReg;
  logic [NUM_CH-1:0][VSEL_W-1:0] cmdVsel;
  logic [NUM_CH-1:0]             absent;
  logic                          cmdUnused;

  assign cmdUnused = ^{cmdWord[15:10], cmdWord[7:2]};

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : gCh
      logic [VSEL_W-1:0] effVsel;
      assign cmdVsel[i] = cmdWord[i*CH_STRIDE +: VSEL_W];
      assign effVsel = cmdValid ? cmdVsel[i] : vselReg[i];
      assign absent[i] = presPin[i] ^ presPolarity;
      assign strobes.clearCh[i]     = cmdValid && (cmdVsel[i] == '0);
      assign strobes.powered[i]     = (effVsel != '0);
      assign strobes.absentFault[i] = strobes.powered[i] && absent[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vselReg[i] <= '0;
        else if (cmdValid) vselReg[i] <= cmdVsel[i];
      end

      // R8: the voltage select only moves on a command strobe
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmdValid |=> $stable(vselReg[i]));
    end
  endgenerate
endmodule

// File: rtl/fault_sup_datapath.sv
`timescale 1ns/1ps
module fault_sup_datapath
  import fault_sup_pkg::*;
#(
  parameter int TIMEOUT_CYCLES    = 16,
  parameter int CLK_WINDOW_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [NUM_CH-1:0] uvFlag,
  input  logic [NUM_CH-1:0] ocFlag,
  input  logic [NUM_CH-1:0] clkMismatch,
  input  logic [NUM_CH-1:0] rstMismatch,
  input  logic              otFlag,
  output logic [NUM_CH-1:0] chanFault,
  output logic [NUM_CH-1:0] deactReq
);
  logic otHit;

  fault_persist_timer #(.LIMIT(TIMEOUT_CYCLES), .ACCUM(1'b0)) uOt (
    .clk(clk), .rst_n(rst_n), .enable(1'b1), .cond(otFlag), .hit(otHit));

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : gCh
      logic uvHit, ocHit, rstHit, clkHit, setHit;

      fault_persist_timer #(.LIMIT(TIMEOUT_CYCLES), .ACCUM(1'b0)) uUv (
        .clk(clk), .rst_n(rst_n), .enable(strobes.powered[i]),
        .cond(uvFlag[i]), .hit(uvHit));
      fault_persist_timer #(.LIMIT(TIMEOUT_CYCLES), .ACCUM(1'b0)) uOc (
        .clk(clk), .rst_n(rst_n), .enable(strobes.powered[i]),
        .cond(ocFlag[i]), .hit(ocHit));
      fault_persist_timer #(.LIMIT(TIMEOUT_CYCLES), .ACCUM(1'b0)) uRst (
        .clk(clk), .rst_n(rst_n), .enable(strobes.powered[i]),
        .cond(rstMismatch[i]), .hit(rstHit));
      fault_persist_timer #(.LIMIT(CLK_WINDOW_CYCLES), .ACCUM(1'b1)) uClk (
        .clk(clk), .rst_n(rst_n), .enable(strobes.powered[i]),
        .cond(clkMismatch[i]), .hit(clkHit));

      assign setHit = uvHit | ocHit | rstHit | clkHit | otHit
                    | strobes.absentFault[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chanFault[i] <= 1'b0;
          deactReq[i]  <= 1'b0;
        end else if (strobes.clearCh[i]) begin
          chanFault[i] <= 1'b0;
          deactReq[i]  <= 1'b0;
        end else begin
          chanFault[i] <= chanFault[i] | setHit;
          deactReq[i]  <= setHit & ~chanFault[i];
        end
      end

      a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        strobes.clearCh[i] |=> !chanFault[i]);
      a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chanFault[i]) |-> deactReq[i]);
      a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        deactReq[i] |=> !deactReq[i]);
      a_r6_absent: assert property (@(posedge clk) disable iff (!rst_n)
        strobes.absentFault[i] |=> chanFault[i]);
      a_r5_ot: assert property (@(posedge clk) disable iff (!rst_n)
        (otHit && !strobes.clearCh[i]) |=> chanFault[i]);
    end
  endgenerate
endmodule

// File: rtl/card_fault_supervisor.sv
`timescale 1ns/1ps
module card_fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int TIMEOUT_CYCLES    = 16,
  parameter int CLK_WINDOW_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [15:0] cmdWord,
  input  logic [1:0]  uvFlag,
  input  logic [1:0]  ocFlag,
  input  logic [1:0]  clkMismatch,
  input  logic [1:0]  rstMismatch,
  input  logic        otFlag,
  input  logic [1:0]  presPin,
  input  logic        presPolarity,
  output logic [15:0] statusWord,
  output logic [1:0]  deactReq
);
  ctrlStrobes_t      strobes;
  logic [NUM_CH-1:0] chanFault;

  fault_sup_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .presPin(presPin), .presPolarity(presPolarity), .strobes(strobes));

  fault_sup_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CLK_WINDOW_CYCLES(CLK_WINDOW_CYCLES)
  ) uData (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .uvFlag(uvFlag),
    .ocFlag(ocFlag), .clkMismatch(clkMismatch), .rstMismatch(rstMismatch),
    .otFlag(otFlag), .chanFault(chanFault), .deactReq(deactReq));

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NUM_CH; i++)
      statusWord[i*CH_STRIDE + STAT_FAULT_BIT] = chanFault[i];
  end

  // R10: only the two fault positions may ever be set
  a_r10_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(statusWord) == $countones(chanFault));
endmodule

// File: tb/tb_card_fault_supervisor.sv
`timescale 1ns/1ps
module tb_card_fault_supervisor;
  localparam int T = 8;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [1:0] uvFlag = '0, ocFlag = '0, clkMismatch = '0, rstMismatch = '0;
  logic otFlag = 1'b0;
  logic [1:0] presPin = '0;
  logic presPolarity = 1'b0;
  logic [15:0] statusWord;
  logic [1:0] deactReq;

  int checks = 0;
  int fails = 0;

  card_fault_supervisor #(.TIMEOUT_CYCLES(T), .CLK_WINDOW_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .uvFlag(uvFlag), .ocFlag(ocFlag), .clkMismatch(clkMismatch),
    .rstMismatch(rstMismatch), .otFlag(otFlag), .presPin(presPin),
    .presPolarity(presPolarity), .statusWord(statusWord), .deactReq(deactReq));

  always #2 clk = ~clk;

  // kind: 0 undervoltage, 1 overcurrent, 2 reset mismatch, 3 clock mismatch
  // columns: kind, channel (0 = B, 1 = A), cycles held, fault expected
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{0, 0, T-1, 0}, '{0, 0, T, 1},
    '{1, 1, T,   1}, '{1, 1, T-1, 0},
    '{2, 0, T,   1}, '{2, 1, T-1, 0},
    '{3, 0, W-1, 0}, '{3, 1, W,   1}
  };
  localparam string VTAG [4] = '{"R1", "R2", "R3", "R4"};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeCmd(logic [15:0] w);
    cmdWord = w;
    cmdValid = 1'b1;
    tick(1);
    cmdValid = 1'b0;
  endtask

  task automatic freshPower();
    writeCmd(16'h0000);
    writeCmd(16'h0101);
  endtask

  task automatic setCond(int kind, int ch, logic v);
    case (kind)
      0: uvFlag[ch] = v;
      1: ocFlag[ch] = v;
      2: rstMismatch[ch] = v;
      default: clkMismatch[ch] = v;
    endcase
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check("R11 status", statusWord, 16'h0000);
    check("R11 deact", {14'd0, deactReq}, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      freshPower();
      setCond(VEC[v][0], VEC[v][1], 1'b1);
      tick(VEC[v][2]);
      setCond(VEC[v][0], VEC[v][1], 1'b0);
      check(VTAG[VEC[v][0]], statusWord,
            VEC[v][3] ? (VEC[v][1] ? 16'h1000 : 16'h0010) : 16'h0000);
    end

    // R4: alternating mismatch still accumulates
    freshPower();
    for (int k = 0; k < W-1; k++) begin
      clkMismatch[0] = 1'b1; tick(1);
      clkMismatch[0] = 1'b0; tick(1);
    end
    check("R4 intermittent below", statusWord, 16'h0000);
    clkMismatch[0] = 1'b1; tick(1); clkMismatch[0] = 1'b0;
    check("R4 intermittent reached", statusWord, 16'h0010);

    // R1: intermittent undervoltage restarts and never faults
    freshPower();
    for (int k = 0; k < 3; k++) begin
      uvFlag[1] = 1'b1; tick(T-1);
      uvFlag[1] = 1'b0; tick(1);
    end
    check("R1 restart", statusWord, 16'h0000);

    // R9: one-cycle request, sticky fault
    freshPower();
    ocFlag[0] = 1'b1;
    tick(T);
    check("R9 request on", {14'd0, deactReq}, 16'h0001);
    tick(1);
    check("R9 request off", {14'd0, deactReq}, 16'h0000);
    ocFlag[0] = 1'b0;
    tick(3);
    check("R9 sticky", statusWord, 16'h0010);

    // R5: over-temperature hits both channels together
    freshPower();
    otFlag = 1'b1;
    tick(T-1);
    check("R5 below", statusWord, 16'h0000);
    tick(1);
    otFlag = 1'b0;
    check("R5 both", statusWord, 16'h1010);

    // R8: clear B only, then A
    writeCmd(16'h0100);
    check("R8 clear B only", statusWord, 16'h1000);
    writeCmd(16'h0000);
    check("R8 clear A", statusWord, 16'h0000);

    // R12: nothing counts while unpowered
    uvFlag = 2'b11; ocFlag = 2'b11; rstMismatch = 2'b11; clkMismatch = 2'b11;
    presPin = 2'b11;
    tick(3 * W);
    check("R12 unpowered", statusWord, 16'h0000);
    uvFlag = '0; ocFlag = '0; rstMismatch = '0; clkMismatch = '0;
    presPin = 2'b01;
    tick(1);

    // R7: power-up request with card B absent
    writeCmd(16'h0001);
    check("R7 power-up absent", statusWord, 16'h0010);
    writeCmd(16'h0000);
    check("R7 cleared", statusWord, 16'h0000);
    presPin = 2'b00;

    // R6: removal with polarity 0
    writeCmd(16'h0101);
    presPin = 2'b10;
    tick(1);
    check("R6 removal pol0", statusWord, 16'h1000);
    check("R6 request", {14'd0, deactReq}, 16'h0002);
    presPin = 2'b00;
    writeCmd(16'h0000);

    // R6: removal with polarity 1 (low pin = absent)
    presPolarity = 1'b1;
    presPin = 2'b11;
    writeCmd(16'h0101);
    tick(2);
    check("R6 present pol1", statusWord, 16'h0000);
    presPin = 2'b10;
    tick(1);
    check("R6 removal pol1", statusWord, 16'h0010);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule